// File: doc/BRIEF.md
# Register Write-Protection Lock Gate

This block sits on a 32-bit host write path in front of a bank of protected configuration registers and a buffer-descriptor RAM. It holds a single lock flag. Software arms the flag, or clears it, by writing one of two exact 32-bit magic values to a dedicated lock register. Any other value, or a write that does not enable all byte lanes, leaves the flag as it was.

While the flag is set, the gate drops host writes that land in the protected configuration window, in the descriptor RAM region, or that carry the power-controller configuration select. Each dropped write produces a one-cycle violation pulse. Reads always pass, and so do writes to any other address. Allowed writes reach the downstream side in the same cycle with nothing changed. The lock register is handled inside the gate. It is never forwarded and never protected, so the unlock code is always accepted. Reading the lock register returns the lock flag in bit 0.

Top module: `wr_lock_gate`

## Requirements
- R1: After synchronous reset the gate is unlocked: `locked` is 0 and `wr_violation` is 0.
- R2: A write to the lock register (address 0x02D05000) with data 0x4C6F436B and all four strobes set causes `locked` to read 1 from the next clock edge.
- R3: A write to the lock register with data 0x6F50654E and all four strobes set causes `locked` to read 0 from the next clock edge.
- R4: A lock-register write with any other data value, or with any strobe bit clear, leaves `locked` unchanged.
- R5: Lock-register writes are never forwarded downstream (`dn_wr_valid` stays 0), and they are accepted in both states.
- R6: While locked, a write with address from 0x02D00000 to 0x02D04FFF inclusive is not forwarded.
- R7: While locked, a write with address from 0x02D08000 to 0x02D09FFF inclusive (the descriptor RAM) is not forwarded.
- R8: While locked, a write with `host_wr_pwr_sel` = 1 is not forwarded, whatever its address (except the lock register).
- R9: Any write that is not the lock register and not blocked is forwarded in the same cycle, with address, data, strobes and power select unchanged.
- R10: Each blocked write drives `wr_violation` high for exactly the one cycle after the write's clock edge. A write that is not blocked leaves it low.
- R11: Reads to any address other than the lock register are forwarded in the same cycle, in both states, and `host_rd_data` returns `dn_rd_data`.
- R12: A read of the lock register is not forwarded and returns 32'h1 when locked and 32'h0 when unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_valid | input | 1 | Host write request |
| host_wr_addr | input | 32 | Host write byte address |
| host_wr_data | input | 32 | Host write data |
| host_wr_strb | input | 4 | Host write byte enables |
| host_wr_pwr_sel | input | 1 | Write targets the power-controller configuration entry |
| host_rd_valid | input | 1 | Host read request |
| host_rd_addr | input | 32 | Host read byte address |
| host_rd_data | output | 32 | Read data returned to host |
| dn_wr_valid | output | 1 | Forwarded write request |
| dn_wr_addr | output | 32 | Forwarded write address |
| dn_wr_data | output | 32 | Forwarded write data |
| dn_wr_strb | output | 4 | Forwarded byte enables |
| dn_wr_pwr_sel | output | 1 | Forwarded power-controller select |
| dn_rd_valid | output | 1 | Forwarded read request |
| dn_rd_addr | output | 32 | Forwarded read address |
| dn_rd_data | input | 32 | Read data from downstream |
| locked | output | 1 | Current lock state |
| wr_violation | output | 1 | One-cycle pulse after a blocked write |

## Verification
Directed writes hit both edges of each protected range and the addresses just outside them, in both lock states. This separates an off-by-one in a range compare from a wrong lock qualifier. The power-select write is sent to an address outside every range, so that select alone decides the outcome. The lock register receives the right codes, codes with one strobe cleared, and near-miss values, which shows whether the full 32-bit value and every lane are compared. A seeded random mix of writes and reads then runs against a bench model of the flag. This catches ordering mistakes in the flag update and in the violation pulse.

// File: rtl/wlg_pkg.sv
package wlg_pkg;

    localparam int unsigned WLG_ADDR_W = 32;
    localparam int unsigned WLG_DATA_W = 32;

    localparam logic [31:0] WLG_LOCK_ADDR   = 32'h02D0_5000;
    localparam logic [31:0] WLG_ARM_CODE    = 32'h4C6F_436B;
    localparam logic [31:0] WLG_DISARM_CODE = 32'h6F50_654E;
    localparam logic [31:0] WLG_WIN_LO      = 32'h02D0_0000;
    localparam logic [31:0] WLG_WIN_HI      = 32'h02D0_4FFF;
    localparam logic [31:0] WLG_DESC_LO     = 32'h02D0_8000;
    localparam logic [31:0] WLG_DESC_HI     = 32'h02D0_9FFF;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_LOCKED = 1'b1
    } lock_state_t;

    typedef struct packed {
        logic is_lock_reg;
        logic in_window;
        logic in_desc;
        logic pwr_sel;
    } wr_class_t;

    function automatic logic in_range(input logic [31:0] a,
                                      input logic [31:0] lo,
                                      input logic [31:0] hi);
        return (a >= lo) && (a <= hi);
    endfunction

    function automatic logic is_protected(input wr_class_t c);
        return !c.is_lock_reg && (c.in_window || c.in_desc || c.pwr_sel);
    endfunction

endpackage

// File: rtl/wlg_addr_decode.sv
module wlg_addr_decode
    import wlg_pkg::*;
#(
    parameter int unsigned  ADDR_W    = WLG_ADDR_W,
    parameter logic [31:0]  LOCK_ADDR = WLG_LOCK_ADDR,
    parameter logic [31:0]  WIN_LO    = WLG_WIN_LO,
    parameter logic [31:0]  WIN_HI    = WLG_WIN_HI,
    parameter logic [31:0]  DESC_LO   = WLG_DESC_LO,
    parameter logic [31:0]  DESC_HI   = WLG_DESC_HI
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              pwr_sel,
    output wr_class_t         cls
);
    logic [31:0] a32;

    always_comb begin
        a32             = 32'(addr);
        cls.is_lock_reg = (a32 == LOCK_ADDR);
        cls.in_window   = in_range(a32, WIN_LO, WIN_HI);
        cls.in_desc     = in_range(a32, DESC_LO, DESC_HI);
        cls.pwr_sel     = pwr_sel;
    end
endmodule

// File: rtl/wlg_lock_state.sv
module wlg_lock_state
    import wlg_pkg::*;
#(
    parameter int unsigned  DATA_W      = WLG_DATA_W,
    parameter logic [31:0]  ARM_CODE    = WLG_ARM_CODE,
    parameter logic [31:0]  DISARM_CODE = WLG_DISARM_CODE,
    localparam int unsigned STRB_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [DATA_W-1:0] data,
    input  logic [STRB_W-1:0] strb,
    output lock_state_t       state
);
    logic full_lanes;
    logic arm_hit;
    logic disarm_hit;

    always_comb begin
        full_lanes = (strb == {STRB_W{1'b1}});
        arm_hit    = hit && full_lanes && (data == DATA_W'(ARM_CODE));
        disarm_hit = hit && full_lanes && (data == DATA_W'(DISARM_CODE));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_OPEN;
        end else if (arm_hit) begin
            state <= ST_LOCKED;
        end else if (disarm_hit) begin
            state <= ST_OPEN;
        end
    end
endmodule

// File: rtl/wlg_wr_filter.sv
module wlg_wr_filter
    import wlg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_valid,
    input  wr_class_t   cls,
    input  lock_state_t state,
    output logic        fwd,
    output logic        lock_hit,
    output logic        violation
);
    logic blocked;

    always_comb begin
        lock_hit = wr_valid && cls.is_lock_reg;
        blocked  = wr_valid && (state == ST_LOCKED) && is_protected(cls);
        fwd      = wr_valid && !cls.is_lock_reg && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            violation <= 1'b0;
        end else begin
            violation <= blocked;
        end
    end
endmodule

// File: rtl/wr_lock_gate.sv
module wr_lock_gate
    import wlg_pkg::*;
#(
    parameter int unsigned  ADDR_W      = WLG_ADDR_W,
    parameter int unsigned  DATA_W      = WLG_DATA_W,
    parameter logic [31:0]  LOCK_ADDR   = WLG_LOCK_ADDR,
    parameter logic [31:0]  ARM_CODE    = WLG_ARM_CODE,
    parameter logic [31:0]  DISARM_CODE = WLG_DISARM_CODE,
    parameter logic [31:0]  WIN_LO      = WLG_WIN_LO,
    parameter logic [31:0]  WIN_HI      = WLG_WIN_HI,
    parameter logic [31:0]  DESC_LO     = WLG_DESC_LO,
    parameter logic [31:0]  DESC_HI     = WLG_DESC_HI,
    localparam int unsigned STRB_W      = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr_valid,
    input  logic [ADDR_W-1:0] host_wr_addr,
    input  logic [DATA_W-1:0] host_wr_data,
    input  logic [STRB_W-1:0] host_wr_strb,
    input  logic              host_wr_pwr_sel,
    input  logic              host_rd_valid,
    input  logic [ADDR_W-1:0] host_rd_addr,
    output logic [DATA_W-1:0] host_rd_data,
    output logic              dn_wr_valid,
    output logic [ADDR_W-1:0] dn_wr_addr,
    output logic [DATA_W-1:0] dn_wr_data,
    output logic [STRB_W-1:0] dn_wr_strb,
    output logic              dn_wr_pwr_sel,
    output logic              dn_rd_valid,
    output logic [ADDR_W-1:0] dn_rd_addr,
    input  logic [DATA_W-1:0] dn_rd_data,
    output logic              locked,
    output logic              wr_violation
);
    wr_class_t   wr_cls;
    wr_class_t   rd_cls;
    lock_state_t lock_st;
    logic        wr_fwd;
    logic        wr_lock_hit;

    wlg_addr_decode #(
        .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .WIN_LO(WIN_LO),
        .WIN_HI(WIN_HI), .DESC_LO(DESC_LO), .DESC_HI(DESC_HI)
    ) u_wr_dec (
        .addr(host_wr_addr), .pwr_sel(host_wr_pwr_sel), .cls(wr_cls)
    );

    wlg_addr_decode #(
        .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR), .WIN_LO(WIN_LO),
        .WIN_HI(WIN_HI), .DESC_LO(DESC_LO), .DESC_HI(DESC_HI)
    ) u_rd_dec (
        .addr(host_rd_addr), .pwr_sel(1'b0), .cls(rd_cls)
    );

    wlg_wr_filter u_filter (
        .clk(clk), .rst(rst), .wr_valid(host_wr_valid), .cls(wr_cls),
        .state(lock_st), .fwd(wr_fwd), .lock_hit(wr_lock_hit),
        .violation(wr_violation)
    );

    wlg_lock_state #(
        .DATA_W(DATA_W), .ARM_CODE(ARM_CODE), .DISARM_CODE(DISARM_CODE)
    ) u_lock (
        .clk(clk), .rst(rst), .hit(wr_lock_hit), .data(host_wr_data),
        .strb(host_wr_strb), .state(lock_st)
    );

    always_comb begin
        locked        = (lock_st == ST_LOCKED);
        dn_wr_valid   = wr_fwd;
        dn_wr_addr    = host_wr_addr;
        dn_wr_data    = host_wr_data;
        dn_wr_strb    = host_wr_strb;
        dn_wr_pwr_sel = host_wr_pwr_sel;
        dn_rd_valid   = host_rd_valid && !rd_cls.is_lock_reg;
        dn_rd_addr    = host_rd_addr;
        if (rd_cls.is_lock_reg) begin
            host_rd_data = DATA_W'(locked);
        end else begin
            host_rd_data = dn_rd_data;
        end
    end
endmodule

// File: rtl/wlg_checker.sv
module wlg_checker
    import wlg_pkg::*;
#(
    parameter int unsigned  ADDR_W      = WLG_ADDR_W,
    parameter int unsigned  DATA_W      = WLG_DATA_W,
    parameter logic [31:0]  LOCK_ADDR   = WLG_LOCK_ADDR,
    parameter logic [31:0]  ARM_CODE    = WLG_ARM_CODE,
    parameter logic [31:0]  DISARM_CODE = WLG_DISARM_CODE,
    parameter logic [31:0]  WIN_LO      = WLG_WIN_LO,
    parameter logic [31:0]  WIN_HI      = WLG_WIN_HI,
    localparam int unsigned STRB_W      = DATA_W / 8
) (
    input logic              clk,
    input logic              rst,
    input logic              host_wr_valid,
    input logic [ADDR_W-1:0] host_wr_addr,
    input logic [DATA_W-1:0] host_wr_data,
    input logic [STRB_W-1:0] host_wr_strb,
    input logic              host_wr_pwr_sel,
    input logic              host_rd_valid,
    input logic [ADDR_W-1:0] host_rd_addr,
    input logic              dn_wr_valid,
    input logic              dn_rd_valid,
    input logic [ADDR_W-1:0] dn_rd_addr,
    input logic              locked,
    input logic              wr_violation
);
    logic prev_rst;
    logic lk_wr;
    logic arm_wr;
    logic disarm_wr;

    always_ff @(posedge clk) prev_rst <= rst;

    always_comb begin
        lk_wr     = host_wr_valid && (32'(host_wr_addr) == LOCK_ADDR);
        arm_wr    = lk_wr && (host_wr_strb == {STRB_W{1'b1}}) && (host_wr_data == DATA_W'(ARM_CODE));
        disarm_wr = lk_wr && (host_wr_strb == {STRB_W{1'b1}}) && (host_wr_data == DATA_W'(DISARM_CODE));
    end

    always_ff @(posedge clk) begin
        if (prev_rst && !rst) begin
            AST_RESET_OPEN: assert (!locked && !wr_violation); // R1
        end
    end

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
        arm_wr |=> locked); // R2

    AST_DISARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
        disarm_wr |=> !locked); // R3

    AST_STATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !(arm_wr || disarm_wr) |=> $stable(locked)); // R4

    AST_LOCKREG_LOCAL: assert property (@(posedge clk) disable iff (rst)
        lk_wr |-> !dn_wr_valid); // R5

    AST_WINDOW_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (locked && host_wr_valid && (32'(host_wr_addr) >= WIN_LO) && (32'(host_wr_addr) <= WIN_HI))
        |-> !dn_wr_valid); // R6

    AST_PWR_VIOLATION: assert property (@(posedge clk) disable iff (rst)
        (locked && host_wr_valid && host_wr_pwr_sel && !lk_wr) |=> wr_violation); // R8

    AST_OPEN_NO_VIOLATION: assert property (@(posedge clk) disable iff (rst)
        (!locked || !host_wr_valid) |=> !wr_violation); // R10

    AST_READ_PASSES: assert property (@(posedge clk) disable iff (rst)
        (host_rd_valid && (32'(host_rd_addr) != LOCK_ADDR))
        |-> (dn_rd_valid && dn_rd_addr == host_rd_addr)); // R11
endmodule

bind wr_lock_gate wlg_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOCK_ADDR(LOCK_ADDR),
    .ARM_CODE(ARM_CODE), .DISARM_CODE(DISARM_CODE),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
    .clk(clk), .rst(rst), .host_wr_valid(host_wr_valid),
    .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_wr_strb(host_wr_strb), .host_wr_pwr_sel(host_wr_pwr_sel),
    .host_rd_valid(host_rd_valid), .host_rd_addr(host_rd_addr),
    .dn_wr_valid(dn_wr_valid), .dn_rd_valid(dn_rd_valid),
    .dn_rd_addr(dn_rd_addr), .locked(locked), .wr_violation(wr_violation)
);

// File: tb/wr_lock_gate_tb.sv
module wr_lock_gate_tb;
    localparam logic [31:0] LK_A   = 32'h02D0_5000;
    localparam logic [31:0] ARM    = 32'h4C6F_436B;
    localparam logic [31:0] DISARM = 32'h6F50_654E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr_valid = 1'b0;
    logic [31:0] host_wr_addr = '0;
    logic [31:0] host_wr_data = '0;
    logic [3:0]  host_wr_strb = '0;
    logic        host_wr_pwr_sel = 1'b0;
    logic        host_rd_valid = 1'b0;
    logic [31:0] host_rd_addr = '0;
    logic [31:0] host_rd_data;
    logic        dn_wr_valid;
    logic [31:0] dn_wr_addr;
    logic [31:0] dn_wr_data;
    logic [3:0]  dn_wr_strb;
    logic        dn_wr_pwr_sel;
    logic        dn_rd_valid;
    logic [31:0] dn_rd_addr;
    logic [31:0] dn_rd_data = '0;
    logic        locked;
    logic        wr_violation;

    int errors = 0;
    int checks = 0;
    bit mdl_locked = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wr_lock_gate u_dut (
        .clk(clk), .rst(rst),
        .host_wr_valid(host_wr_valid), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_wr_strb(host_wr_strb),
        .host_wr_pwr_sel(host_wr_pwr_sel),
        .host_rd_valid(host_rd_valid), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data),
        .dn_wr_valid(dn_wr_valid), .dn_wr_addr(dn_wr_addr),
        .dn_wr_data(dn_wr_data), .dn_wr_strb(dn_wr_strb),
        .dn_wr_pwr_sel(dn_wr_pwr_sel),
        .dn_rd_valid(dn_rd_valid), .dn_rd_addr(dn_rd_addr),
        .dn_rd_data(dn_rd_data),
        .locked(locked), .wr_violation(wr_violation)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit prot(input logic [31:0] a, input bit pwr);
        if (a == LK_A) return 1'b0;
        return (a >= 32'h02D0_0000 && a <= 32'h02D0_4FFF) ||
               (a >= 32'h02D0_8000 && a <= 32'h02D0_9FFF) || pwr;
    endfunction

    function automatic string req_of(input logic [31:0] a, input bit pwr);
        if (a == LK_A) return "R5";
        if (a >= 32'h02D0_0000 && a <= 32'h02D0_4FFF) return "R6";
        if (a >= 32'h02D0_8000 && a <= 32'h02D0_9FFF) return "R7";
        if (pwr) return "R8";
        return "R9";
    endfunction

    task automatic do_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input bit pwr);
        bit is_lk;
        bit blk;
        bit exp_fwd;
        string rq;
        @(negedge clk);
        chk(wr_violation == 1'b0, "R10", 32'(wr_violation), 32'h0);
        host_wr_valid = 1'b1; host_wr_addr = a; host_wr_data = d;
        host_wr_strb = s; host_wr_pwr_sel = pwr;
        is_lk   = (a == LK_A);
        blk     = mdl_locked && prot(a, pwr);
        exp_fwd = !is_lk && !blk;
        rq      = blk ? req_of(a, pwr) : (is_lk ? "R5" : "R9");
        #1;
        chk(dn_wr_valid == exp_fwd, rq, 32'(dn_wr_valid), 32'(exp_fwd));
        if (exp_fwd) begin
            chk(dn_wr_addr == a && dn_wr_data == d && dn_wr_strb == s && dn_wr_pwr_sel == pwr,
                "R9", dn_wr_data, d);
        end
        if (is_lk && s == 4'hF && d == ARM) mdl_locked = 1'b1;
        else if (is_lk && s == 4'hF && d == DISARM) mdl_locked = 1'b0;
        @(posedge clk); #1;
        chk(wr_violation == blk, "R10", 32'(wr_violation), 32'(blk));
        chk(locked == mdl_locked, is_lk ? "R4" : "R4", 32'(locked), 32'(mdl_locked));
        @(negedge clk);
        host_wr_valid = 1'b0;
    endtask

    task automatic do_rd(input logic [31:0] a, input logic [31:0] dd, input string rq);
        @(negedge clk);
        host_rd_valid = 1'b1; host_rd_addr = a; dn_rd_data = dd;
        #1;
        if (a == LK_A) begin
            chk(dn_rd_valid == 1'b0, "R12", 32'(dn_rd_valid), 32'h0);
            chk(host_rd_data == 32'(mdl_locked), rq, host_rd_data, 32'(mdl_locked));
        end else begin
            chk(dn_rd_valid && dn_rd_addr == a, "R11", dn_rd_addr, a);
            chk(host_rd_data == dd, rq, host_rd_data, dd);
        end
        @(negedge clk);
        host_rd_valid = 1'b0;
    endtask

    function automatic logic [31:0] pick_addr(input int k);
        case (k % 8)
            0: return 32'h02D0_0000 + ($urandom % 32'h5000);
            1: return 32'h02D0_8000 + ($urandom % 32'h2000);
            2: return LK_A;
            3: return 32'h02D0_4FFF;
            4: return 32'h02D0_A000;
            5: return 32'h02CF_FFFC;
            6: return 32'h02D0_7FFC;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(locked == 1'b0, "R1", 32'(locked), 32'h0);
        chk(wr_violation == 1'b0, "R1", 32'(wr_violation), 32'h0);

        // R9: unlocked, protected ranges pass
        do_wr(32'h02D0_0000, 32'h1111_2222, 4'hF, 1'b0);
        do_wr(32'h02D0_8000, 32'h3333_4444, 4'h3, 1'b1);
        // R4: near misses
        do_wr(LK_A, ARM, 4'h7, 1'b0);
        do_wr(LK_A, ARM ^ 32'h1, 4'hF, 1'b0);
        do_wr(LK_A, DISARM, 4'hF, 1'b0);
        do_rd(LK_A, 32'hDEAD_BEEF, "R12");
        // R2: arm
        do_wr(LK_A, ARM, 4'hF, 1'b0);
        do_rd(LK_A, 32'hDEAD_BEEF, "R12");
        // R6 edges
        do_wr(32'h02D0_0000, 32'hA, 4'hF, 1'b0);
        do_wr(32'h02D0_4FFF, 32'hB, 4'hF, 1'b0);
        do_wr(32'h02CF_FFFF, 32'hC, 4'hF, 1'b0);
        do_wr(32'h02D0_5004, 32'hD, 4'hF, 1'b0);
        // R7 edges
        do_wr(32'h02D0_8000, 32'hE, 4'hF, 1'b0);
        do_wr(32'h02D0_9FFF, 32'hF, 4'hF, 1'b0);
        do_wr(32'h02D0_A000, 32'h10, 4'hF, 1'b0);
        do_wr(32'h02D0_7FFF, 32'h11, 4'hF, 1'b0);
        // R8
        do_wr(32'h1000_0000, 32'h12, 4'hF, 1'b1);
        // R11 while locked
        do_rd(32'h02D0_0010, 32'h5555_AAAA, "R11");
        // R4 while locked: partial disarm ignored, rearm harmless
        do_wr(LK_A, DISARM, 4'hE, 1'b0);
        do_wr(LK_A, ARM, 4'hF, 1'b1);
        // R3
        do_wr(LK_A, DISARM, 4'hF, 1'b0);
        do_rd(LK_A, 32'h0, "R12");
        do_wr(32'h02D0_1000, 32'h13, 4'hF, 1'b0);

        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k == 8) begin
                do_wr(LK_A, ($urandom % 2) ? ARM : DISARM, ($urandom % 4 == 0) ? 4'hB : 4'hF, 1'b0);
            end else if (k == 9) begin
                do_rd(($urandom % 3 == 0) ? LK_A : pick_addr(int'($urandom)), $urandom, "R11");
            end else begin
                do_wr(pick_addr(k), $urandom, 4'($urandom), ($urandom % 5) == 0);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule